// File: doc/BRIEF.md
# Up/Down Pulse Counter with Selectable Clear Policy

This block keeps a signed 32-bit running total of pulses seen on an asynchronous count line. Each rising edge of that line moves the total by one. A direction line picks whether the step adds or subtracts. Counting runs only while the run bit of an 8-bit command byte is set. Dropping the run bit freezes the total, and raising it again carries on from the frozen value.

The clear bit of the command byte is read differently under each of two clear policies, picked by a policy select input:
- **Strobed policy:** the total returns to zero on the next periodic refresh strobe that arrives while the clear bit is set.
- **Index policy:** the clear bit only arms an asynchronous index line, and a rising edge on that line zeroes the total.

The block also holds a range-comparison result word and an output pattern word. An external comparison engine loads both words. A separate command bit wipes both.

The count, direction and index lines are brought into the clock domain by multi-flop synchronizers. The command byte and the policy select are registered once before they take effect.

Top module: `edge_counter_top`

## Requirements
- R1: With command bit 0 (run) low, rising edges on the count line leave `presentValue` unchanged.
- R2: Setting the run bit again continues counting from the held value; starting never zeroes the total.
- R3: With run high, each rising edge of `cntIn` adds one when `dirIn` is 0 and subtracts one when `dirIn` is 1. The total is two's complement and wraps modulo 2^32.
- R4: With `clrPolicy` = 0 (strobed) and command bit 1 (clear) high, a one-cycle `refreshStb` zeroes the total. With the clear bit low, a refresh leaves it unchanged.
- R5: With `clrPolicy` = 1 (index), a rising edge on `idxIn` zeroes the total only while the clear bit is high. When the clear bit is low, index edges are ignored. Refresh strobes never clear in this policy.
- R6: A clear, whether from a refresh or from the index line, takes priority over a count edge arriving in the same cycle, and the result is zero.
- R7: With command bit 4 high, both `cmpResult` and `patternOut` read zero on the next cycle, and this beats a simultaneous `cmpLoad`. With bit 4 low, both words keep their value until loaded.
- R8: Command bits 2, 3, 5, 6 and 7 have no effect on the total or on the comparison words.
- R9: After reset the total is zero, the counter is stopped, the policy is strobed, and both comparison words are zero.
- R10: The count line is sampled through two synchronizer flops. A pulse of any width of at least one clock adds exactly one step, visible three clock edges after its rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| cntIn | input | 1 | Asynchronous count pulse line |
| dirIn | input | 1 | Asynchronous direction, 0 up, 1 down |
| idxIn | input | 1 | Asynchronous index line |
| refreshStb | input | 1 | One-cycle periodic refresh strobe |
| clrPolicy | input | 1 | 0 strobed clear, 1 index clear |
| cmdBits | input | 8 | Command byte: bit 0 run, bit 1 clear/arm, bit 4 wipe comparison words |
| cmpLoad | input | 1 | Load strobe for the comparison words |
| cmpResultIn | input | 8 | Comparison result to load |
| patternIn | input | 16 | Output pattern to load |
| presentValue | output | 32 | Signed running total |
| cmpResult | output | 8 | Held comparison result |
| patternOut | output | 16 | Held output pattern |

## Verification
The assertions take for granted that the command byte is never unknown once reset is released. They also assume that each clear, load or count edge is seen by the datapath as a single-cycle strobe, so a step is exactly plus or minus one per cycle.

The stimulus holds each count and index pulse for three clocks and keeps it low for three more, so every pulse produces exactly one synchronized edge. Direction is settled before the count edge it applies to. Command and policy changes are made on falling clock edges, one full cycle before the event they govern.

// File: rtl/edge_counter_pkg.sv
package edge_counter_pkg;

  localparam int CMD_W      = 8;
  localparam int CMD_RUN    = 0;
  localparam int CMD_CLEAR  = 1;
  localparam int CMD_CMPCLR = 4;

  typedef struct packed {
    logic countEn;
    logic countDown;
    logic clear;
    logic cmpClear;
  } cnt_strobe_t;

endpackage

// File: rtl/edge_counter_sync.sv
module edge_counter_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rstN) chain <= '0;
    else       chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];

endmodule

// File: rtl/edge_counter_ctrl.sv
module edge_counter_ctrl
  import edge_counter_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntIn,
  input  logic             dirIn,
  input  logic             idxIn,
  input  logic             refreshStb,
  input  logic             clrPolicy,
  input  logic [CMD_W-1:0] cmdBits,
  output cnt_strobe_t      strb
);

  logic cntSync, dirSync, idxSync;
  logic cntPrev, idxPrev;
  logic runQ, clearQ, cmpClrQ, policyQ;
  logic cntRise, idxRise;

  // one synchronizer per asynchronous line
  edge_counter_sync #(.STAGES(SYNC_STAGES)) cntSync_i (
    .clk(clk), .rstN(rstN), .d(cntIn), .q(cntSync));
  edge_counter_sync #(.STAGES(SYNC_STAGES)) dirSync_i (
    .clk(clk), .rstN(rstN), .d(dirIn), .q(dirSync));
  edge_counter_sync #(.STAGES(SYNC_STAGES)) idxSync_i (
    .clk(clk), .rstN(rstN), .d(idxIn), .q(idxSync));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntPrev <= 1'b0;
      idxPrev <= 1'b0;
      runQ    <= 1'b0;
      clearQ  <= 1'b0;
      cmpClrQ <= 1'b0;
      policyQ <= 1'b0;
    end else begin
      cntPrev <= cntSync;
      idxPrev <= idxSync;
      runQ    <= cmdBits[CMD_RUN];
      clearQ  <= cmdBits[CMD_CLEAR];
      cmpClrQ <= cmdBits[CMD_CMPCLR];
      policyQ <= clrPolicy;
    end
  end

  assign cntRise = cntSync & ~cntPrev;
  assign idxRise = idxSync & ~idxPrev;

  always_comb begin
    strb.countEn   = runQ & cntRise;
    strb.countDown = dirSync;
    strb.cmpClear  = cmpClrQ;
    if (policyQ) strb.clear = clearQ & idxRise;
    else         strb.clear = clearQ & refreshStb;
  end

  AST_CMD_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    !$isunknown(cmdBits)) else $error("command byte unknown"); // R8

  AST_UNARMED_NO_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    !clearQ |-> !strb.clear) else $error("clear without arm"); // R4

  AST_STOPPED_NO_STEP: assert property (@(posedge clk) disable iff (!rstN)
    !runQ |-> !strb.countEn) else $error("step while stopped"); // R1

endmodule

// File: rtl/edge_counter_dp.sv
module edge_counter_dp
  import edge_counter_pkg::*;
#(
  parameter int CNT_W = 32,
  parameter int CMP_W = 8,
  parameter int PAT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  cnt_strobe_t      strb,
  input  logic             cmpLoad,
  input  logic [CMP_W-1:0] cmpResultIn,
  input  logic [PAT_W-1:0] patternIn,
  output logic [CNT_W-1:0] presentValue,
  output logic [CMP_W-1:0] cmpResult,
  output logic [PAT_W-1:0] patternOut
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  always_ff @(posedge clk) begin
    if (!rstN)              presentValue <= '0;
    else if (strb.clear)    presentValue <= '0;
    else if (strb.countEn)  presentValue <= strb.countDown ? presentValue - ONE
                                                           : presentValue + ONE;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.cmpClear) begin
      cmpResult  <= '0;
      patternOut <= '0;
    end else if (cmpLoad) begin
      cmpResult  <= cmpResultIn;
      patternOut <= patternIn;
    end
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> presentValue == '0) else $error("clear lost"); // R6

  AST_STEP_UP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.clear && !strb.countDown)
      |=> presentValue == $past(presentValue) + ONE) else $error("bad up step"); // R3

  AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rstN)
    (strb.countEn && !strb.clear && strb.countDown)
      |=> presentValue == $past(presentValue) - ONE) else $error("bad down step"); // R3

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.countEn && !strb.clear) |=> $stable(presentValue)) else $error("value drift"); // R1

  AST_CMP_WIPE: assert property (@(posedge clk) disable iff (!rstN)
    strb.cmpClear |=> (cmpResult == '0 && patternOut == '0)) else $error("wipe lost"); // R7

endmodule

// File: rtl/edge_counter_top.sv
module edge_counter_top
  import edge_counter_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int CMP_W       = 8,
  parameter int PAT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cntIn,
  input  logic             dirIn,
  input  logic             idxIn,
  input  logic             refreshStb,
  input  logic             clrPolicy,
  input  logic [CMD_W-1:0] cmdBits,
  input  logic             cmpLoad,
  input  logic [CMP_W-1:0] cmpResultIn,
  input  logic [PAT_W-1:0] patternIn,
  output logic [CNT_W-1:0] presentValue,
  output logic [CMP_W-1:0] cmpResult,
  output logic [PAT_W-1:0] patternOut
);

  cnt_strobe_t strb;

  edge_counter_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .cntIn(cntIn), .dirIn(dirIn), .idxIn(idxIn),
    .refreshStb(refreshStb), .clrPolicy(clrPolicy), .cmdBits(cmdBits),
    .strb(strb));

  edge_counter_dp #(.CNT_W(CNT_W), .CMP_W(CMP_W), .PAT_W(PAT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cmpLoad(cmpLoad),
    .cmpResultIn(cmpResultIn), .patternIn(patternIn),
    .presentValue(presentValue), .cmpResult(cmpResult), .patternOut(patternOut));

endmodule

// File: tb/edge_counter_top_tb_top.sv
`timescale 1ns/1ps
module edge_counter_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cntIn = 1'b0, dirIn = 1'b0, idxIn = 1'b0;
  logic        refreshStb = 1'b0, clrPolicy = 1'b0, cmpLoad = 1'b0;
  logic [7:0]  cmdBits = 8'h00;
  logic [7:0]  cmpResultIn = 8'h00;
  logic [15:0] patternIn = 16'h0000;
  logic [31:0] presentValue;
  logic [7:0]  cmpResult;
  logic [15:0] patternOut;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  localparam logic [7:0] RUN = 8'h01, CLR = 8'h02, WIPE = 8'h10;

  always #2 clk = ~clk;

  edge_counter_top dut_i (
    .clk(clk), .rstN(rstN), .cntIn(cntIn), .dirIn(dirIn), .idxIn(idxIn),
    .refreshStb(refreshStb), .clrPolicy(clrPolicy), .cmdBits(cmdBits),
    .cmpLoad(cmpLoad), .cmpResultIn(cmpResultIn), .patternIn(patternIn),
    .presentValue(presentValue), .cmpResult(cmpResult), .patternOut(patternOut));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic setCmd(input logic [7:0] v);
    @(negedge clk); cmdBits = v; @(negedge clk);
  endtask

  task automatic setPolicy(input logic p);
    @(negedge clk); clrPolicy = p; @(negedge clk);
  endtask

  task automatic pulseCnt(input logic down);
    @(negedge clk); dirIn = down; cntIn = 1'b1;
    repeat (3) @(negedge clk);
    cntIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseIdx();
    @(negedge clk); idxIn = 1'b1;
    repeat (3) @(negedge clk);
    idxIn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic pulseRefresh();
    @(negedge clk); refreshStb = 1'b1;
    @(negedge clk); refreshStb = 1'b0;
    @(negedge clk);
  endtask

  task automatic loadCmp(input logic [7:0] r, input logic [15:0] p);
    @(negedge clk); cmpResultIn = r; patternIn = p; cmpLoad = 1'b1;
    @(negedge clk); cmpLoad = 1'b0;
  endtask

  task automatic testReset();
    check("R9 value", presentValue, 32'h0);
    check("R9 cmp", {24'h0, cmpResult}, 32'h0);
    check("R9 pattern", {16'h0, patternOut}, 32'h0);
    pulseCnt(1'b0);
    check("R9 stopped after reset", presentValue, 32'h0);
  endtask

  task automatic testUpDown();
    setCmd(RUN);
    pulseCnt(1'b0);
    check("R10 single step", presentValue, 32'h1);
    repeat (4) pulseCnt(1'b0);
    check("R3 up count", presentValue, 32'h5);
    repeat (7) pulseCnt(1'b1);
    check("R3 down wrap", presentValue, 32'hFFFF_FFFE);
  endtask

  task automatic testStopResume();
    setCmd(8'h00);
    repeat (3) pulseCnt(1'b0);
    check("R1 hold while stopped", presentValue, 32'hFFFF_FFFE);
    setCmd(RUN);
    check("R2 start keeps value", presentValue, 32'hFFFF_FFFE);
    repeat (3) pulseCnt(1'b0);
    check("R2 resume from held", presentValue, 32'h1);
  endtask

  task automatic testReserved();
    loadCmp(8'h3C, 16'hBEEF);
    setCmd(RUN | 8'hEC);
    repeat (2) pulseCnt(1'b0);
    check("R8 count unaffected", presentValue, 32'h3);
    check("R8 cmp unaffected", {24'h0, cmpResult}, 32'h3C);
    check("R8 pattern unaffected", {16'h0, patternOut}, 32'hBEEF);
    setCmd(RUN);
  endtask

  task automatic testStrobed();
    pulseRefresh();
    check("R4 refresh unarmed", presentValue, 32'h3);
    setCmd(RUN | CLR);
    check("R4 no clear before refresh", presentValue, 32'h3);
    pulseRefresh();
    check("R4 refresh clears", presentValue, 32'h0);
    setCmd(RUN);
  endtask

  task automatic testIndex();
    setPolicy(1'b1);
    repeat (4) pulseCnt(1'b0);
    check("R5 count in index policy", presentValue, 32'h4);
    pulseIdx();
    check("R5 index ignored unarmed", presentValue, 32'h4);
    setCmd(RUN | CLR);
    pulseRefresh();
    check("R5 refresh no clear", presentValue, 32'h4);
    pulseIdx();
    check("R5 armed index clears", presentValue, 32'h0);
  endtask

  task automatic testPriority();
    repeat (2) pulseCnt(1'b0);
    check("R6 setup index", presentValue, 32'h2);
    @(negedge clk); dirIn = 1'b0; cntIn = 1'b1; idxIn = 1'b1;
    repeat (3) @(negedge clk);
    cntIn = 1'b0; idxIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 index beats count", presentValue, 32'h0);
    setCmd(RUN);
    setPolicy(1'b0);
    repeat (3) pulseCnt(1'b0);
    check("R6 setup strobed", presentValue, 32'h3);
    setCmd(RUN | CLR);
    @(negedge clk); cntIn = 1'b1;
    repeat (2) @(negedge clk);
    refreshStb = 1'b1;
    @(negedge clk); refreshStb = 1'b0; cntIn = 1'b0;
    repeat (3) @(negedge clk);
    check("R6 refresh beats count", presentValue, 32'h0);
    setCmd(RUN);
  endtask

  task automatic testWipe();
    loadCmp(8'hA5, 16'h1234);
    check("R7 loaded cmp", {24'h0, cmpResult}, 32'hA5);
    repeat (4) @(negedge clk);
    check("R7 held pattern", {16'h0, patternOut}, 32'h1234);
    @(negedge clk); cmdBits = RUN | WIPE; cmpResultIn = 8'h77; patternIn = 16'h5555; cmpLoad = 1'b1;
    @(negedge clk);
    @(negedge clk); cmpLoad = 1'b0;
    check("R7 wipe cmp", {24'h0, cmpResult}, 32'h0);
    check("R7 wipe pattern", {16'h0, patternOut}, 32'h0);
    setCmd(RUN);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testUpDown();
    testStopResume();
    testReserved();
    testStrobed();
    testIndex();
    testPriority();
    testWipe();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule